// File: doc/BRIEF.md
# Address Match Hardware Breakpoint Unit

This block sits beside a processor core and watches every bus access the core makes. It holds a small bank of breakpoint slots. Each slot names an address, the kind of access it reacts to (instruction fetch, data load or data store) and how many low address bits are left out of the compare. Leaving bits out turns a single address into an aligned zone. When a qualifying access falls inside an armed zone, the unit raises a trap request in the following cycle. It also reports which slots hit and the lowest-numbered slot among them.

The comparison only observes addresses. The unit has no path into memory, so code and data at a breakpoint address stay untouched, and breakpoints placed in read-only memory work the same as any others. Software programs the slots and a global enable bit through a small select/write-enable/data register port. It acknowledges a trap once it has handled it. While the core reports that it is running its debug handler, no new trap is taken.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, trap_req, hit_slot and hit_vec are 0, the global enable is 0, and every register reads back 0, so all slots are disabled.
- R2: A slot register (select 0 to 3) holds the compare address in bits [23:0], the access type in bits [25:24] and the ignore count in bits [30:26]. The control register (select 4) holds the global enable in bit 0 and reads 0 elsewhere. A write is visible on cfg_rdata (combinational read) from the next cycle on. Selects 5 to 7 read 0.
- R3: Access type codes are 00 disabled, 01 fetch, 10 load and 11 store, on both bus_kind and the slot type. A slot matches only a valid access whose bus_kind equals its nonzero type.
- R4: With ignore count N, address bits below N are left out of the compare. An address differing from the slot address only in those bits matches, and one differing in any bit at or above N does not. A count of 24 or more matches every address.
- R5: A matching access in cycle t sets trap_req high after the clock edge that ends cycle t. hit_vec then shows every slot that matched in cycle t (bit k for slot k).
- R6: hit_slot gives the lowest-numbered slot set in hit_vec.
- R7: Once set, trap_req, hit_slot and hit_vec hold unchanged until trap_ack is sampled high. Matches during that time are discarded. The acknowledge clears all three on the next edge.
- R8: No trap is taken while the global enable is 0 or while in_debug is 1.
- R9: A register write takes effect on the next clock. An access in the same cycle as the write is compared against the old slot contents.
- R10: No match is made while bus_valid is 0, whatever the address and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-3 slots, 4 control |
| cfg_wdata | input | 31 | Register write data |
| cfg_rdata | output | 31 | Register read data for cfg_sel |
| bus_valid | input | 1 | Core bus access present this cycle |
| bus_kind | input | 2 | Access type code of the bus access |
| bus_addr | input | 24 | Address of the bus access |
| in_debug | input | 1 | Core is running its debug handler |
| trap_ack | input | 1 | Software acknowledge of the pending trap |
| trap_req | output | 1 | Trap request to the core |
| hit_slot | output | 2 | Lowest slot that hit |
| hit_vec | output | 4 | One bit per slot that hit |

## Verification
The bench sweeps every slot against every type code and bus kind. It then sweeps the ignore count from 0 through 25 while flipping each address bit one at a time. A wrong mask boundary shows up as a zone one bit too wide or too narrow, and a wrong type decode lets loads fire fetch breakpoints or lets type 00 fire. The bench also programs overlapping zones so that different slots become the lowest hit, which catches an encoder that picks the highest slot. It checks that a second hit while a trap is pending does not overwrite the report. Finally, it writes a slot and probes its new address in the same cycle; a design that forwards write data into the compare would trap there.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_FETCH = 2'b01,
    KIND_LOAD  = 2'b10,
    KIND_STORE = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MASK_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W+2+MASK_W-1:0]     wdata,
  input  logic                           bus_valid,
  input  logic [1:0]                     bus_kind,
  input  logic [ADDR_W-1:0]              bus_addr,
  output logic [ADDR_W+2+MASK_W-1:0]     rdata,
  output logic                           hit
);
  localparam int KIND_LSB = ADDR_W;
  localparam int CNT_LSB  = ADDR_W + 2;
  localparam int REG_W    = CNT_LSB + MASK_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  acc_kind_e         kind_q, kind_d;
  logic [MASK_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] care;
  logic [ADDR_W-1:0] diff;
  logic              kind_ok;

  // next-state: load all fields on a write, else hold
  always_comb begin
    addr_d = addr_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    if (wr_en) begin
      addr_d = wdata[ADDR_W-1:0];
      kind_d = acc_kind_e'(wdata[KIND_LSB +: 2]);
      cnt_d  = wdata[CNT_LSB +: MASK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= KIND_NONE;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
    end
  end

  // a bit takes part in the compare only at or above the ignore count
  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      care[i] = (i >= int'(cnt_q));
    end
  end

  assign diff    = (bus_addr ^ addr_q) & care;
  assign kind_ok = (kind_q != KIND_NONE) && (bus_kind == 2'(kind_q));
  assign hit     = bus_valid && kind_ok && (diff == '0);
  assign rdata   = {cnt_q, 2'(kind_q), addr_q};

  // R2: a written value reads back on the following cycle
  assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == $past(wdata[REG_W-1:0]));

  // R4: the exact programmed address always lies inside the zone
  assert_exact_in_zone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && kind_q != KIND_NONE && bus_kind == 2'(kind_q) && bus_addr == addr_q) |-> hit);

  // R10: no hit without a valid access
  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !hit);
endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N-1:0] lower;

  // scan downward so the lowest set bit is written last
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

  always_comb begin
    lower = vec & ((N'(1) << idx) - N'(1));
    if (any) begin
      assert_lowest_R6: assert (vec[idx] && lower == '0);
    end
  end
endmodule

// File: rtl/bkpt_trap.sv
module bkpt_trap #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  match_vec,
  input  logic [IW-1:0] match_idx,
  input  logic          match_any,
  input  logic          allow,
  input  logic          ack,
  output logic          trap_req,
  output logic [IW-1:0] hit_idx,
  output logic [N-1:0]  hit_vec
);
  logic          trap_q, trap_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [N-1:0]  vec_q, vec_d;
  logic          capture, release_t;

  assign capture   = !trap_q && allow && match_any;
  assign release_t = trap_q && ack;

  always_comb begin
    trap_d = trap_q;
    idx_d  = idx_q;
    vec_d  = vec_q;
    if (capture) begin
      trap_d = 1'b1;
      idx_d  = match_idx;
      vec_d  = match_vec;
    end else if (release_t) begin
      trap_d = 1'b0;
      idx_d  = '0;
      vec_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else begin
      trap_q <= trap_d;
      idx_q  <= idx_d;
      vec_q  <= vec_d;
    end
  end

  assign trap_req = trap_q;
  assign hit_idx  = idx_q;
  assign hit_vec  = vec_q;

  assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && allow && match_any) |=>
      (trap_req && hit_vec == $past(match_vec) && hit_idx == $past(match_idx)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !ack) |=> (trap_req && $stable(hit_vec) && $stable(hit_idx)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && ack) |=> (!trap_req && hit_vec == '0));

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !allow) |=> !trap_req);

  assert_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (hit_vec != '0 && hit_vec[hit_idx]));
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 24,
  parameter int MASK_W    = 5,
  localparam int REG_W    = ADDR_W + 2 + MASK_W,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int SEL_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic [REG_W-1:0]      cfg_wdata,
  output logic [REG_W-1:0]      cfg_rdata,
  input  logic                  bus_valid,
  input  logic [1:0]            bus_kind,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  in_debug,
  input  logic                  trap_ack,
  output logic                  trap_req,
  output logic [IDX_W-1:0]      hit_slot,
  output logic [NUM_SLOTS-1:0]  hit_vec
);
  localparam int CTRL_SEL = NUM_SLOTS;

  logic                 en_q, en_d;
  logic [REG_W-1:0]     slot_rd [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] match_vec;
  logic [IDX_W-1:0]     match_idx;
  logic                 match_any;
  logic                 allow;

  // global enable register
  always_comb begin
    en_d = en_q;
    if (cfg_we && cfg_sel == SEL_W'(CTRL_SEL)) en_d = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      logic wr_k;
      assign wr_k = cfg_we && (cfg_sel == SEL_W'(k));
      bkpt_slot #(
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_k),
        .wdata     (cfg_wdata),
        .bus_valid (bus_valid),
        .bus_kind  (bus_kind),
        .bus_addr  (bus_addr),
        .rdata     (slot_rd[k]),
        .hit       (match_vec[k])
      );
    end
  endgenerate

  // register read mux
  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (cfg_sel == SEL_W'(k)) cfg_rdata = slot_rd[k];
    end
    if (cfg_sel == SEL_W'(CTRL_SEL)) cfg_rdata = REG_W'(en_q);
  end

  bkpt_prio #(
    .N  (NUM_SLOTS),
    .IW (IDX_W)
  ) u_prio (
    .vec (match_vec),
    .idx (match_idx),
    .any (match_any)
  );

  assign allow = en_q && !in_debug;

  bkpt_trap #(
    .N  (NUM_SLOTS),
    .IW (IDX_W)
  ) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_vec (match_vec),
    .match_idx (match_idx),
    .match_any (match_any),
    .allow     (allow),
    .ack       (trap_ack),
    .trap_req  (trap_req),
    .hit_idx   (hit_slot),
    .hit_vec   (hit_vec)
  );

  // R8: with the enable off, a trap never starts
  assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !trap_req) |=> !trap_req);

  // R8: while the handler runs, a trap never starts
  assert_in_debug_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_debug && !trap_req) |=> !trap_req);
endmodule

// File: tb/bkpt_unit_test.sv
`timescale 1ns/1ps
module bkpt_unit_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [30:0] cfg_wdata;
  logic [30:0] cfg_rdata;
  logic        bus_valid;
  logic [1:0]  bus_kind;
  logic [23:0] bus_addr;
  logic        in_debug;
  logic        trap_ack;
  logic        trap_req;
  logic [1:0]  hit_slot;
  logic [3:0]  hit_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [23:0] m_addr [4];
  logic [1:0]  m_kind [4];
  int          m_n    [4];
  bit          m_en;

  bkpt_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
    .bus_kind(bus_kind), .bus_addr(bus_addr), .in_debug(in_debug),
    .trap_ack(trap_ack), .trap_req(trap_req), .hit_slot(hit_slot),
    .hit_vec(hit_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] enc(logic [23:0] a, logic [1:0] t, int n);
    return {5'(n), t, a};
  endfunction

  function automatic logic [3:0] exp_vec(logic [1:0] k, logic [23:0] a);
    logic [3:0] v = '0;
    for (int s = 0; s < 4; s++) begin
      logic [23:0] care = (m_n[s] >= 24) ? 24'h0 : (24'hFFFFFF << m_n[s]);
      v[s] = (m_kind[s] != 2'b00) && (k == m_kind[s]) && (((a ^ m_addr[s]) & care) == 24'h0);
    end
    return v;
  endfunction

  function automatic logic [1:0] lowest(logic [3:0] v);
    for (int s = 0; s < 4; s++) if (v[s]) return 2'(s);
    return 2'd0;
  endfunction

  task automatic wr(logic [2:0] sel, logic [30:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_slot(int k, logic [23:0] a, logic [1:0] t, int n);
    wr(3'(k), enc(a, t, n));
    m_addr[k] = a; m_kind[k] = t; m_n[k] = n;
  endtask

  task automatic set_en(bit e);
    wr(3'd4, 31'(e));
    m_en = e;
  endtask

  task automatic clear_all;
    for (int k = 0; k < 4; k++) set_slot(k, 24'h0, 2'b00, 0);
  endtask

  task automatic ack;
    @(negedge clk);
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
  endtask

  // one bus access, check the report a cycle later, then acknowledge
  task automatic probe(logic [1:0] k, logic [23:0] a, string tag);
    logic [3:0] ev;
    bit         et;
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = k; bus_addr = a;
    ev = exp_vec(k, a);
    et = m_en && !in_debug && (ev != 4'h0);
    @(negedge clk);
    bus_valid = 1'b0;
    chk({tag, " trap_req"}, 32'(trap_req), 32'(et));
    if (et) begin
      chk({tag, " hit_vec"}, 32'(hit_vec), 32'(ev));
      chk({tag, " hit_slot"}, 32'(hit_slot), 32'(lowest(ev)));
    end
    ack();
    chk({tag, " cleared"}, 32'(trap_req), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_kind = '0; bus_addr = '0; in_debug = 1'b0; trap_ack = 1'b0;
    for (int k = 0; k < 4; k++) begin m_addr[k] = 0; m_kind[k] = 0; m_n[k] = 0; end
    m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 trap_req", 32'(trap_req), 0);
    chk("R1 hit_vec", 32'(hit_vec), 0);
    chk("R1 hit_slot", 32'(hit_slot), 0);
    for (int s = 0; s < 8; s++) begin
      cfg_sel = 3'(s); #1;
      chk("R1 reg reset", 32'(cfg_rdata), 0);
    end

    // R2: readback of every slot and control register
    for (int k = 0; k < 4; k++) begin
      logic [30:0] v = enc(24'hC0FFEE ^ 24'(k * 24'h111111), 2'(k), 7 + k * 6);
      wr(3'(k), v);
      cfg_sel = 3'(k); #1;
      chk("R2 slot readback", 32'(cfg_rdata), 32'(v));
    end
    wr(3'd5, 31'h7FFFFFFF);
    cfg_sel = 3'd5; #1;
    chk("R2 unmapped reads zero", 32'(cfg_rdata), 0);
    wr(3'd4, 31'h7FFFFFFF);
    cfg_sel = 3'd4; #1;
    chk("R2 control readback", 32'(cfg_rdata), 1);
    m_en = 1;
    clear_all();

    // R3: every slot against every type and bus kind
    for (int k = 0; k < 4; k++) begin
      for (int t = 0; t < 4; t++) begin
        clear_all();
        set_slot(k, 24'h123456 + 24'(k * 24'h111), 2'(t), 0);
        for (int bk = 0; bk < 4; bk++) probe(2'(bk), m_addr[k], "R3 type");
      end
    end

    // R4: zone boundary sweep over every count and address bit
    clear_all();
    for (int n = 0; n < 26; n++) begin
      set_slot(2, 24'hA5C3F0, 2'b10, n);
      probe(2'b10, 24'hA5C3F0, "R4 exact");
      for (int b = 0; b < 24; b++) probe(2'b10, 24'hA5C3F0 ^ (24'h1 << b), "R4 zone");
    end

    // R5/R6: overlapping zones, different lowest slots
    set_slot(0, 24'h001000, 2'b01, 0);
    set_slot(1, 24'h001000, 2'b01, 4);
    set_slot(2, 24'h001000, 2'b01, 8);
    set_slot(3, 24'h000000, 2'b01, 24);
    probe(2'b01, 24'h001000, "R6 all four");
    probe(2'b01, 24'h001008, "R6 slot1 lowest");
    probe(2'b01, 24'h001080, "R6 slot2 lowest");
    probe(2'b01, 24'h0F0000, "R6 slot3 only");
    probe(2'b11, 24'h001000, "R5 wrong kind");
    for (int i = 0; i < 32; i++) probe(2'b01, 24'h000F00 + 24'(i * 24'h11), "R5 scan");

    // R7: pending trap holds against a later hit
    clear_all();
    set_slot(1, 24'h00AA00, 2'b01, 0);
    set_slot(0, 24'h00BB00, 2'b10, 0);
    @(negedge clk); bus_valid = 1; bus_kind = 2'b01; bus_addr = 24'h00AA00;
    @(negedge clk); bus_kind = 2'b10; bus_addr = 24'h00BB00;
    @(negedge clk); bus_valid = 0;
    chk("R7 held trap", 32'(trap_req), 1);
    chk("R7 held vec", 32'(hit_vec), 32'h2);
    chk("R7 held slot", 32'(hit_slot), 1);
    repeat (3) @(negedge clk);
    chk("R7 still held", 32'(trap_req), 1);
    ack();
    chk("R7 ack clears", 32'(trap_req), 0);
    chk("R7 ack clears vec", 32'(hit_vec), 0);

    // R8: global enable and debug gating
    set_en(0);
    probe(2'b01, 24'h00AA00, "R8 disabled");
    set_en(1);
    in_debug = 1'b1;
    probe(2'b01, 24'h00AA00, "R8 in_debug");
    in_debug = 1'b0;
    probe(2'b01, 24'h00AA00, "R8 re-enabled");

    // R9: same-cycle write uses old contents
    clear_all();
    set_slot(0, 24'h111111, 2'b01, 0);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'd0; cfg_wdata = enc(24'h777000, 2'b01, 0);
    bus_valid = 1; bus_kind = 2'b01; bus_addr = 24'h777000;
    @(negedge clk);
    cfg_we = 0; bus_valid = 0;
    chk("R9 old config used", 32'(trap_req), 0);
    m_addr[0] = 24'h777000;
    probe(2'b01, 24'h777000, "R9 new config");

    // R10: no access when bus_valid is low
    @(negedge clk); bus_valid = 0; bus_kind = 2'b01; bus_addr = 24'h777000;
    @(negedge clk);
    chk("R10 idle bus", 32'(trap_req), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule